// File: doc/BRIEF.md
# Single-Shot Falling-Edge Pattern Detector

This block watches one serial data bit per clock and raises a flag the first time the stream shows a one followed by a zero. After that detection the detector is disarmed. Further one-then-zero pairs are ignored until the stream shows two zeros in a row. That pair of zeros returns the machine to its idle state, and it is armed again.

The machine has four states held in a 2-bit register: idle, one-seen, fired-and-waiting, and first-zero-after-firing. Next-state decoding, the state register and the output are three separate pieces of logic. The flag is a Mealy output. It is valid in the same cycle as the zero that completes the pattern, so a consumer registers it at the next rising edge. Reset is synchronous, active low and takes priority over the data. The flag stays low after power-up until reset has been applied at least once.

Top module: `single_shot_detect`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, the machine enters idle regardless of `din`. In the cycle after such an edge `hit` is 0 whatever `din` is.
- R2: From idle a 1 moves to one-seen and a 0 keeps idle. In one-seen a further 1 keeps one-seen. So `hit` is high only in a cycle whose preceding cycle had `din` = 1.
- R3: `hit` is combinational. It is 1 exactly when the machine is in one-seen, `din` is 0 and `rst_n` is 1. It responds within the same cycle, before the next clock edge.
- R4: A detection moves the machine to fired-and-waiting. No second detection can occur in the cycle after a detection.
- R5: While fired, a 1 holds the fired state and a single 0 moves to first-zero. A 1 there returns to fired. Only a second consecutive 0 re-arms to idle, so one-then-zero pairs separated by single zeros raise no flag.
- R6: While `rst_n` is 0, `hit` is 0 even if the machine is in one-seen and `din` is 0.
- R7: From power-up, `hit` stays 0 until `rst_n` has been sampled low at least once.
- R8: After a reset, the stream 0001110101101100101111 (first bit first) gives `hit` = 0000001000000000010000.
- R9: Over arbitrary streams with reset pulses at arbitrary points, `hit` matches an arm/disarm model in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low, priority over data |
| din | input | 1 | Serial data bit |
| hit | output | 1 | Detection flag, combinational from state and `din` |

## Verification
The bench targets the re-arm path. It sends streams where single zeros separate one-zero pairs after a detection; a design that re-armed on one zero would flag again there. It asserts reset while the machine sits in one-seen with `din` low. A design that let data win over reset, or gated the flag with the registered reset only, would pulse `hit` in that cycle. It drives patterns before any reset to expose a flag that depends on the unknown power-up state. A randomized run with random reset pulses compares every cycle against a model built on a zero counter, which catches mis-routed transitions out of the first-zero state.

// File: rtl/single_shot_detect.sv
module single_shot_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_DONE = 2'b11,
    ST_ZERO = 2'b10
  } st_t;

  st_t  st, st_nx;
  logic rst_seen = 1'b0;

  always_comb begin
    case (st)
      ST_IDLE: st_nx = din ? ST_ONE  : ST_IDLE;
      ST_ONE:  st_nx = din ? ST_ONE  : ST_DONE;
      ST_DONE: st_nx = din ? ST_DONE : ST_ZERO;
      ST_ZERO: st_nx = din ? ST_DONE : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk) rst_seen <= rst_seen | ~rst_n;

  assign hit = rst_seen & rst_n & (st == ST_ONE) & ~din;

  p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> !hit);

  p_hit_after_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(din));

  p_hit_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !din);

  p_single_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  p_lone_zero_keeps_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit ##1 !din ##1 din |=> !hit);

  p_reset_masks_flag_r6: assert property (@(posedge clk) !rst_n |-> !hit);

  p_quiet_before_reset_r7: assert property (@(posedge clk) !rst_seen |-> !hit);
endmodule

// File: tb/tb_single_shot_detect.sv
`timescale 1ns/1ps
module tb_single_shot_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic din = 1'b0;
  logic hit;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic m_armed = 1'b1, m_prev = 1'b0, m_seen = 1'b0;
  int   m_zc = 0;

  always #2.5 clk = ~clk;

  single_shot_detect dut (.clk(clk), .rst_n(rst_n), .din(din), .hit(hit));

  task automatic check(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns later, model advances at posedge
  task automatic step(input logic d, input logic r, output logic got, output logic mexp);
    @(negedge clk);
    din = d; rst_n = r;
    #1;
    got  = hit;
    mexp = m_seen & r & m_armed & m_prev & ~d;
    @(posedge clk);
    if (!r) begin
      m_armed = 1'b1; m_prev = 1'b0; m_zc = 0; m_seen = 1'b1;
    end else if (m_armed) begin
      if (m_prev && !d) begin m_armed = 1'b0; m_zc = 0; end
      m_prev = d;
    end else begin
      m_zc = d ? 0 : m_zc + 1;
      if (m_zc == 2) begin m_armed = 1'b1; m_prev = 1'b0; m_zc = 0; end
    end
  endtask

  task automatic t_powerup;
    logic g, e;
    logic [5:0] pat = 6'b101010;
    for (int i = 5; i >= 0; i--) begin
      step(pat[i], 1'b1, g, e);
      check(g, 1'b0, "R7 no flag before first reset");
    end
  endtask

  task automatic t_reset_state;
    logic g, e;
    step(1'b0, 1'b0, g, e);
    check(g, 1'b0, "R1 flag low during reset");
    step(1'b0, 1'b1, g, e);
    check(g, 1'b0, "R1 idle after reset, zero gives no flag");
  endtask

  task automatic t_golden;
    logic g, e;
    logic [21:0] s = 22'b0001110101101100101111;
    logic [21:0] x = 22'b0000001000000000010000;
    step(1'b0, 1'b0, g, e);
    for (int i = 21; i >= 0; i--) begin
      step(s[i], 1'b1, g, e);
      check(g, x[i], "R8 golden stream");
    end
  endtask

  task automatic t_reset_priority;
    logic g, e;
    step(1'b0, 1'b0, g, e);
    step(1'b1, 1'b1, g, e);
    check(g, 1'b0, "R2 one from idle gives no flag");
    step(1'b1, 1'b1, g, e);
    check(g, 1'b0, "R2 one-seen holds on one");
    step(1'b0, 1'b0, g, e);
    check(g, 1'b0, "R6 reset masks flag in one-seen");
    step(1'b0, 1'b1, g, e);
    check(g, 1'b0, "R1 reset forced idle over data");
    step(1'b1, 1'b1, g, e);
    step(1'b0, 1'b1, g, e);
    check(g, 1'b1, "R3 flag same cycle as zero");
    step(1'b0, 1'b1, g, e);
    check(g, 1'b0, "R4 no flag right after detection");
  endtask

  task automatic t_rearm;
    logic g, e;
    step(1'b0, 1'b0, g, e);
    step(1'b1, 1'b1, g, e);
    step(1'b0, 1'b1, g, e);
    check(g, 1'b1, "R3 first detection");
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, g, e);
      step(1'b0, 1'b1, g, e);
      check(g, 1'b0, "R5 single zero does not re-arm");
    end
    step(1'b0, 1'b1, g, e);
    check(g, 1'b0, "R5 second zero re-arms quietly");
    step(1'b1, 1'b1, g, e);
    step(1'b0, 1'b1, g, e);
    check(g, 1'b1, "R5 detection after re-arm");
  endtask

  task automatic t_random;
    logic g, e;
    step(1'b0, 1'b0, g, e);
    for (int i = 0; i < 3000; i++) begin
      logic d = logic'($urandom_range(0, 1));
      logic r = ($urandom_range(0, 99) < 3) ? 1'b0 : 1'b1;
      step(d, r, g, e);
      check(g, e, "R9 random vs model");
    end
  endtask

  initial begin
    t_powerup();
    t_reset_state();
    t_golden();
    t_reset_priority();
    t_rearm();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: hit=%b expected=done at %0t", hit, $time);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule